// File: doc/BRIEF.md
# Block-Cipher Register Front-End

This block sits between a 32-bit register bus and a 128-bit block-cipher core. Software, or a DMA engine acting for it, loads up to eight key words, a four-word initialisation vector, a control word and a byte count. Plaintext or ciphertext blocks then go in as four 32-bit writes to a small data window. Once the fourth word lands, the front-end hands the packed block to the cipher core through a start/done port. The result waits in the same window until four reads drain it.

Two DMA request lines pace the transfers in four-word bursts. The input request asks for the next block and the output request asks for the result to be collected. A byte-length register counts down by one block each time a block is accepted. After each block the front-end updates the vector itself: it adds one to the counter in counter mode and chains the previous block in CBC mode. A soft-reset bit returns the whole block to its idle state.

The sequencer has four states. FILL collects input words and is left on the fourth word, with the transition "block accepted". LAUNCH lasts one cycle and pulses the core start, with the transition "always". RUN waits for the core, with the transition "core done". DRAIN hands out the result and returns to FILL on the fourth read, with the transition "block drained".

Top module: `cipher_frontend`

## Requirements
- R1: After reset, the control word reads 0x0000_0002 (bit 1 input-ready set, bit 0 output-ready clear), the length register (word address 18) reads 0 and both DMA requests are low.
- R2: Key word i (0..7) is written at word address 7 - (i XOR 1) and drives bits [32i+31:32i] of `eng_key`. The IV words 0..3 sit at word addresses 8..11, word 0 least significant, and read back as written.
- R3: The control word at address 12 keeps bits 8:2 as written: bit 2 direction (1 encrypt), bits 4:3 key size ((bytes/8)-1), bit 5 CBC, bit 6 counter mode, bits 8:7 counter width (0=32, 1=64, 2=96, 3=128). These bits appear on `eng_cfg[6:0]`. Bits 0 and 1 are read-only status.
- R4: Four writes to the data window (addresses 13..16, word k at 13+k) pack word k into bits [32k+31:32k] of `eng_block`. The fourth write clears input-ready and produces exactly one single-cycle `eng_start` pulse.
- R5: After `eng_done`, control bit 0 is set and reads of 13+k return result word k. After four data reads, bit 0 clears and bit 1 sets again.
- R6: A write to address 18 loads the remaining byte count. Each accepted block lowers it by 16, saturating at 0, and address 18 reads the current count.
- R7: `dma_in_req` is high only in FILL while system-mask bit 2 (input DMA enable) and bit 5 (start) are set and the remaining count is non-zero. It drops after the fourth word of the burst.
- R8: `dma_out_req` is high only while a result is waiting and system-mask bit 3 (output DMA enable) is set. It drops after the fourth read.
- R9: Writing the system mask (address 17) with start and both DMA enables clear lowers any active request from the next cycle on.
- R10: In counter mode, on core completion, the low 32·(width+1) bits of the IV increment with wrap and the upper bits are unchanged.
- R11: In CBC mode (counter mode off), on completion the IV becomes the result block when encrypting and the input block when decrypting.
- R12: A system-mask write with bit 1 set clears the key, IV, control, mask, length and both buffers in that cycle. Bit 1 reads back as 0, and the block returns to FILL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (data-window reads advance the drain) |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| dma_in_req | output | 1 | Request for a four-word input burst |
| dma_out_req | output | 1 | Request to collect a four-word result burst |
| eng_start | output | 1 | One-cycle start to the cipher core |
| eng_block | output | 128 | Packed input block |
| eng_key | output | 256 | Key words |
| eng_iv | output | 128 | Current chaining / counter value |
| eng_cfg | output | 7 | Control bits 8:2 |
| eng_done | input | 1 | Core completion pulse |
| eng_result | input | 128 | Core result, valid with eng_done |

## Verification
The hardest case to reach is the counter wrap at each width boundary, because the IV only changes as a side effect of a complete fill, run and drain sequence. The bench loads IV patterns of all ones, and a pattern with only the low word saturated. It runs one block per counter width through a stub core and reads the IV back, so a carry that leaks past or stops short of the selected width shows up. The DMA request lines are observed across a two-block length countdown, including the point where the count runs out.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 4;
    localparam int BLK_W     = WORD_W * BLK_WORDS;
    localparam int KEY_WORDS = 8;
    localparam int CFG_W     = 7;

    localparam int A_KEY_TOP = 7;
    localparam int A_IV      = 8;
    localparam int A_CTRL    = 12;
    localparam int A_DATA    = 13;
    localparam int A_SYS     = 17;
    localparam int A_LEN0    = 18;
    localparam int A_LEN1    = 19;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN    = 2'd2,
        ST_DRAIN  = 2'd3
    } blk_state_e;
endpackage

// File: rtl/cfe_iv_step.sv
module cfe_iv_step #(
    parameter int SEG_W = 32,
    parameter int N_SEG = 4
) (
    input  logic [SEG_W*N_SEG-1:0] iv_cur,
    input  logic [SEG_W*N_SEG-1:0] blk_in,
    input  logic [SEG_W*N_SEG-1:0] blk_out,
    input  logic [1:0]             width_sel,
    input  logic                   ctr_on,
    input  logic                   cbc_on,
    input  logic                   encrypt,
    output logic [SEG_W*N_SEG-1:0] iv_next
);
    localparam int TOT_W = SEG_W * N_SEG;

    logic [TOT_W-1:0] cand [N_SEG];

    for (genvar g = 0; g < N_SEG; g++) begin : g_width
        localparam int W = (g + 1) * SEG_W;
        if (W == TOT_W) begin : g_full
            assign cand[g] = iv_cur + TOT_W'(1);
        end else begin : g_part
            assign cand[g] = {iv_cur[TOT_W-1:W], iv_cur[W-1:0] + W'(1)};
        end
    end

    always_comb begin
        if (ctr_on)
            iv_next = cand[width_sel];
        else if (cbc_on)
            iv_next = encrypt ? blk_out : blk_in;
        else
            iv_next = iv_cur;
    end
endmodule

// File: rtl/cfe_block_fsm.sv
module cfe_block_fsm
    import cfe_pkg::*;
#(
    parameter int N_WORDS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic       eng_done,
    input  logic       in_en,
    input  logic       out_en,
    input  logic       go,
    input  logic       rem_nz,
    output blk_state_e state,
    output logic       accept,
    output logic       eng_start,
    output logic       in_ready,
    output logic       out_ready,
    output logic       in_req,
    output logic       out_req
);
    localparam int CW = $clog2(N_WORDS);
    localparam logic [CW-1:0] LAST = CW'(N_WORDS - 1);

    blk_state_e      state_nx;
    logic [CW-1:0]   wcnt, wcnt_nx;

    always_comb begin
        state_nx = state;
        wcnt_nx  = wcnt;
        unique case (state)
            ST_FILL: if (data_wr) begin
                wcnt_nx = (wcnt == LAST) ? '0 : wcnt + CW'(1);
                if (wcnt == LAST) state_nx = ST_LAUNCH;
            end
            ST_LAUNCH: state_nx = ST_RUN;
            ST_RUN: if (eng_done) state_nx = ST_DRAIN;
            ST_DRAIN: if (data_rd) begin
                wcnt_nx = (wcnt == LAST) ? '0 : wcnt + CW'(1);
                if (wcnt == LAST) state_nx = ST_FILL;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state <= ST_FILL;
            wcnt  <= '0;
        end else begin
            state <= state_nx;
            wcnt  <= wcnt_nx;
        end
    end

    always_comb begin
        accept    = (state == ST_FILL) && data_wr && (wcnt == LAST);
        eng_start = (state == ST_LAUNCH);
        in_ready  = (state == ST_FILL);
        out_ready = (state == ST_DRAIN);
        in_req    = in_ready && in_en && go && rem_nz;
        out_req   = out_ready && out_en;
    end
endmodule

// File: rtl/cipher_frontend.sv
module cipher_frontend
    import cfe_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LEN_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 dma_in_req,
    output logic                 dma_out_req,
    output logic                 eng_start,
    output logic [BLK_W-1:0]     eng_block,
    output logic [KEY_WORDS*WORD_W-1:0] eng_key,
    output logic [BLK_W-1:0]     eng_iv,
    output logic [CFG_W-1:0]     eng_cfg,
    input  logic                 eng_done,
    input  logic [BLK_W-1:0]     eng_result
);
    localparam int KI_W = $clog2(KEY_WORDS);
    localparam int DI_W = $clog2(BLK_WORDS);
    localparam logic [LEN_W-1:0] BLK_BYTES = LEN_W'(BLK_W / 8);

    logic [WORD_W-1:0] key_q [KEY_WORDS];
    logic [WORD_W-1:0] iv_q  [BLK_WORDS];
    logic [WORD_W-1:0] in_q  [BLK_WORDS];
    logic [WORD_W-1:0] out_q [BLK_WORDS];
    logic [CFG_W-1:0]  ctrl_q;
    logic              in_en_q, out_en_q, go_q, idle_q;
    logic [LEN_W-1:0]  rem_q;

    blk_state_e st;
    logic accept, in_ready, out_ready;
    logic [BLK_W-1:0] iv_nx;

    logic hit_key, hit_iv, hit_data, sreset, data_wr, data_rd;
    logic [KI_W-1:0] kidx;
    logic [DI_W-1:0] ividx, didx;

    assign hit_key  = bus_addr <= ADDR_W'(A_KEY_TOP);
    assign hit_iv   = (bus_addr >= ADDR_W'(A_IV)) && (bus_addr < ADDR_W'(A_IV + BLK_WORDS));
    assign hit_data = (bus_addr >= ADDR_W'(A_DATA)) && (bus_addr < ADDR_W'(A_DATA + BLK_WORDS));
    assign kidx     = KI_W'(ADDR_W'(A_KEY_TOP) - bus_addr) ^ KI_W'(1);
    assign ividx    = DI_W'(bus_addr - ADDR_W'(A_IV));
    assign didx     = DI_W'(bus_addr - ADDR_W'(A_DATA));
    assign sreset   = bus_wr && (bus_addr == ADDR_W'(A_SYS)) && bus_wdata[1];
    assign data_wr  = bus_wr && hit_data;
    assign data_rd  = bus_rd && hit_data;

    for (genvar k = 0; k < BLK_WORDS; k++) begin : g_blk
        assign eng_block[k*WORD_W +: WORD_W] = in_q[k];
        assign eng_iv[k*WORD_W +: WORD_W]    = iv_q[k];
    end
    for (genvar k = 0; k < KEY_WORDS; k++) begin : g_key
        assign eng_key[k*WORD_W +: WORD_W] = key_q[k];
    end
    assign eng_cfg = ctrl_q;

    cfe_block_fsm #(.N_WORDS(BLK_WORDS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .clr(sreset),
        .data_wr(data_wr), .data_rd(data_rd), .eng_done(eng_done),
        .in_en(in_en_q), .out_en(out_en_q), .go(go_q), .rem_nz(rem_q != '0),
        .state(st), .accept(accept), .eng_start(eng_start),
        .in_ready(in_ready), .out_ready(out_ready),
        .in_req(dma_in_req), .out_req(dma_out_req)
    );

    cfe_iv_step #(.SEG_W(WORD_W), .N_SEG(BLK_WORDS)) step_i (
        .iv_cur(eng_iv), .blk_in(eng_block), .blk_out(eng_result),
        .width_sel(ctrl_q[6:5]), .ctr_on(ctrl_q[4]), .cbc_on(ctrl_q[3]),
        .encrypt(ctrl_q[0]), .iv_next(iv_nx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || sreset) begin
            for (int i = 0; i < KEY_WORDS; i++) key_q[i] <= '0;
            for (int i = 0; i < BLK_WORDS; i++) begin
                iv_q[i]  <= '0;
                in_q[i]  <= '0;
                out_q[i] <= '0;
            end
            ctrl_q   <= '0;
            in_en_q  <= 1'b0;
            out_en_q <= 1'b0;
            go_q     <= 1'b0;
            idle_q   <= 1'b0;
            rem_q    <= '0;
        end else begin
            if (st == ST_RUN && eng_done) begin
                for (int i = 0; i < BLK_WORDS; i++) begin
                    out_q[i] <= eng_result[i*WORD_W +: WORD_W];
                    iv_q[i]  <= iv_nx[i*WORD_W +: WORD_W];
                end
            end
            if (accept)
                rem_q <= (rem_q >= BLK_BYTES) ? rem_q - BLK_BYTES : '0;
            if (bus_wr) begin
                if (hit_key) key_q[kidx] <= bus_wdata;
                if (hit_iv) iv_q[ividx] <= bus_wdata;
                if (data_wr && st == ST_FILL) in_q[didx] <= bus_wdata;
                if (bus_addr == ADDR_W'(A_CTRL)) ctrl_q <= bus_wdata[8:2];
                if (bus_addr == ADDR_W'(A_LEN0)) rem_q <= bus_wdata[LEN_W-1:0];
                if (bus_addr == ADDR_W'(A_SYS)) begin
                    idle_q   <= bus_wdata[0];
                    in_en_q  <= bus_wdata[2];
                    out_en_q <= bus_wdata[3];
                    go_q     <= bus_wdata[5];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_key)
            bus_rdata = key_q[kidx];
        else if (hit_iv)
            bus_rdata = iv_q[ividx];
        else if (hit_data)
            bus_rdata = out_ready ? out_q[didx] : '0;
        else if (bus_addr == ADDR_W'(A_CTRL))
            bus_rdata = {{(WORD_W-CFG_W-2){1'b0}}, ctrl_q, in_ready, out_ready};
        else if (bus_addr == ADDR_W'(A_SYS))
            bus_rdata = {{(WORD_W-6){1'b0}}, go_q, 1'b0, out_en_q, in_en_q, 1'b0, idle_q};
        else if (bus_addr == ADDR_W'(A_LEN0))
            bus_rdata = {{(WORD_W-LEN_W){1'b0}}, rem_q};
    end
endmodule

// File: rtl/cipher_frontend_chk.sv
module cipher_frontend_chk
    import cfe_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              dma_in_req,
    input logic              dma_out_req,
    input logic              eng_start,
    input logic              eng_done,
    input logic [LEN_W-1:0]  rem_q,
    input blk_state_e        st,
    input logic [CFG_W-1:0]  ctrl_q,
    input logic [WORD_W-1:0] iv_top
);
    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R7
    in_req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_in_req |-> (rem_q != '0));

    // R8
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_in_req, dma_out_req, eng_start}));

    // R8
    out_req_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_out_req) |-> (st == ST_DRAIN));

    // R12
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_SYS) && bus_wdata[1])
        |=> (rem_q == '0 && !dma_in_req && !dma_out_req && st == ST_FILL));

    // R10
    ctr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && eng_done && !bus_wr && ctrl_q[4] && ctrl_q[6:5] != 2'd3)
        |=> (iv_top == $past(iv_top)));
endmodule

bind cipher_frontend cipher_frontend_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
    .eng_start(eng_start), .eng_done(eng_done), .rem_q(rem_q), .st(st),
    .ctrl_q(ctrl_q), .iv_top(iv_q[3])
);

// File: tb/cipher_frontend_tb.sv
module cipher_frontend_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic dma_in_req, dma_out_req, eng_start, eng_done;
    logic [127:0] eng_block, eng_iv, eng_result;
    logic [255:0] eng_key;
    logic [6:0] eng_cfg;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cipher_frontend #(.ADDR_W(ADDR_W), .LEN_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
        .eng_start(eng_start), .eng_block(eng_block), .eng_key(eng_key),
        .eng_iv(eng_iv), .eng_cfg(eng_cfg), .eng_done(eng_done),
        .eng_result(eng_result)
    );

    // stub core: result = block ^ iv ^ low key half, done three cycles after start
    logic [2:0] stub_cnt = '0;
    logic [127:0] stub_res = '0;
    logic stub_done = 1'b0;
    always @(posedge clk) begin
        if (eng_start) begin
            stub_cnt <= 3'd3;
            stub_res <= eng_block ^ eng_iv ^ eng_key[127:0];
        end else if (stub_cnt != 0) begin
            stub_cnt <= stub_cnt - 3'd1;
        end
        stub_done <= (stub_cnt == 3'd1) && !eng_start;
    end
    assign eng_done   = stub_done;
    assign eng_result = stub_res;

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = ADDR_W'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = ADDR_W'(a);
        #1 d = bus_rdata;
    endtask

    task automatic push_block(input logic [127:0] b);
        for (int k = 0; k < 4; k++) wr(13 + k, b[k*32 +: 32]);
    endtask

    task automatic wait_result;
        logic [31:0] c;
        for (int i = 0; i < 40; i++) begin
            peek(12, c);
            if (c[0]) break;
        end
    endtask

    task automatic pull_block(output logic [127:0] r);
        logic [31:0] d;
        for (int k = 0; k < 4; k++) begin
            rd(13 + k, d);
            r[k*32 +: 32] = d;
        end
    endtask

    task automatic read_iv(output logic [127:0] v);
        logic [31:0] d;
        for (int k = 0; k < 4; k++) begin
            peek(8 + k, d);
            v[k*32 +: 32] = d;
        end
    endtask

    task automatic load_iv(input logic [127:0] v);
        for (int k = 0; k < 4; k++) wr(8 + k, v[k*32 +: 32]);
    endtask

    function automatic logic [127:0] ctr_expect(input logic [127:0] v, input int w);
        logic [127:0] m;
        m = (w == 3) ? '1 : ((128'd1 << ((w + 1) * 32)) - 128'd1);
        return (v & ~m) | ((v + 128'd1) & m);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done_flag) begin
            done_flag = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<50000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [255:0] kexp;
        logic [127:0] blk, res, ivv, iv0, exp_iv;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(12, d); check("R1 ctrl", d, 32'h2);
        peek(18, d); check("R1 len", d, 0);
        check("R1 reqs", {dma_in_req, dma_out_req}, 0);

        // R2 key placement
        for (int i = 0; i < 8; i++) begin
            wr(7 - (i ^ 1), 32'hA000_0000 + i * 32'h0101);
            kexp[i*32 +: 32] = 32'hA000_0000 + i * 32'h0101;
        end
        check("R2 key bus", eng_key, kexp);
        iv0 = {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001};
        load_iv(iv0);
        read_iv(ivv); check("R2 iv readback", ivv, iv0);

        // R3 control field
        wr(12, 32'h1FF);
        peek(12, d); check("R3 ctrl rw", d, 32'h1FE);
        check("R3 eng_cfg", eng_cfg, 7'h7F);
        wr(12, 32'h0C);           // encrypt, 128-bit key, ECB
        check("R3 keysz", eng_cfg[2:1], 2'd1);

        // R4/R5/R6/R7/R8 with DMA and length countdown
        wr(18, 32);
        wr(17, 32'h2C);
        check("R7 in req on", dma_in_req, 1);
        blk = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
        for (int k = 0; k < 3; k++) wr(13 + k, blk[k*32 +: 32]);
        check("R7 in req mid-burst", dma_in_req, 1);
        wr(16, blk[127:96]);
        #1 check("R4 start pulse", eng_start, 1);
        check("R4 packed block", eng_block, blk);
        check("R7 in req after burst", dma_in_req, 0);
        peek(12, d); check("R4 input ready clear", d[1:0], 2'b00);
        peek(18, d); check("R6 len after block 1", d, 16);
        wait_result;
        check("R8 out req", dma_out_req, 1);
        check("R8 no in req while draining", dma_in_req, 0);
        pull_block(res);
        check("R5 result", res, blk ^ iv0 ^ kexp[127:0]);
        check("R8 out req dropped", dma_out_req, 0);
        peek(12, d); check("R5 ready flags", d[1:0], 2'b10);
        check("R7 in req second block", dma_in_req, 1);
        blk = ~blk;
        push_block(blk);
        peek(18, d); check("R6 len zero", d, 0);
        wait_result; pull_block(res);
        check("R7 no req at zero length", dma_in_req, 0);
        wr(18, 8);
        push_block(blk);
        peek(18, d); check("R6 saturate", d, 0);
        wait_result; pull_block(res);

        // R8 output enable off
        wr(17, 32'h24);
        push_block(blk);
        wait_result;
        check("R8 disabled out req", dma_out_req, 0);
        pull_block(res);

        // R9 stop by clearing enables and start
        wr(18, 64); wr(17, 32'h2C);
        check("R9 req before stop", dma_in_req, 1);
        wr(17, 32'h00);
        check("R9 req after stop", dma_in_req, 0);

        // R10 counter width sweep, two IV patterns
        for (int w = 0; w < 4; w++) begin
            for (int p = 0; p < 2; p++) begin
                ivv = (p == 0) ? '1 : {32'h0, 32'h0, 32'h5, 32'hFFFF_FFFF};
                load_iv(ivv);
                wr(12, 32'h4C | (w << 7));
                push_block(128'h1234);
                wait_result; pull_block(res);
                read_iv(exp_iv);
                check($sformatf("R10 ctr w%0d p%0d", w, p), exp_iv, ctr_expect(ivv, w));
            end
        end

        // R11 CBC chaining, encrypt then decrypt
        load_iv(iv0);
        wr(12, 32'h2C);
        blk = 128'hDEAD_BEEF_0000_1111_2222_3333_4444_5555;
        push_block(blk); wait_result; pull_block(res);
        read_iv(ivv); check("R11 cbc encrypt iv", ivv, blk ^ iv0 ^ kexp[127:0]);
        wr(12, 32'h28);
        push_block(blk); wait_result; pull_block(res);
        read_iv(ivv); check("R11 cbc decrypt iv", ivv, blk);

        // R12 soft reset mid-fill
        wr(18, 48); wr(17, 32'h2D);
        wr(13, 32'h55);
        wr(17, 32'h02);
        peek(17, d); check("R12 mask reads zero", d, 0);
        peek(12, d); check("R12 ctrl", d, 32'h2);
        peek(18, d); check("R12 len", d, 0);
        peek(6, d);  check("R12 key", d, 0);
        read_iv(ivv); check("R12 iv", ivv, 0);
        check("R12 reqs", {dma_in_req, dma_out_req}, 0);
        push_block(128'h77);
        #1 check("R12 fill restarted", eng_block, 128'h77);
        wait_result; pull_block(res);
        check("R12 result after reset", res, 128'h77);

        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule